// File: doc/BRIEF.md
# Dual Chebyshev Chaos Sample Generator

The block produces two chaotic sample streams in signed 16-bit fixed point. Each stream holds a state in the closed unit interval and, on every step, replaces it with a Chebyshev polynomial of that state. The first stream uses the quadratic map T2(s) = 2s² − 1 and the second uses the cubic map T3(s) = 4s³ − 3s. These forms follow from the recurrence with T0 = 1 and T1 = s.

A finite word length pulls such a map into short cycles. To prevent this, every step flips the least significant bit of each new state by XOR with a pseudo-random bit. Each stream draws its bit from its own on-chip Gold sequence generator. A Gold generator combines two maximal-length shift registers of equal degree. The two streams share one polynomial pair but start the second register at different seeds, so their bit sequences run at different phases.

A consumer asserts the step input once per wanted sample and reads both samples together with the valid strobe. A reset, or the seed-load input, restarts both maps and all shift registers from their parameter seeds. This makes a run repeatable.

Top module: `chaos_pair_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is as follows: `src0_o` = INIT0, `src1_o` = INIT1, `out_valid_o` = 0, and every shift register holds its seed. Samples are signed Q1.14, so 16384 represents +1.0.
- R2: On a step, `src0_o` becomes clamp(f(s) XOR g0), where s is the previous `src0_o`. Here f(s) = 2·p − 16384, p = (s·s) >>> 14, and >>> is an arithmetic shift that rounds toward minus infinity. g0 is bit 0 of the first stream's Gold generator. The XOR acts on bit 0 of the two's-complement value.
- R3: On a step, `src1_o` becomes clamp(h(s) XOR g1). Here h(s) = 4·q − 3·s, p = (s·s) >>> 14, q = (p·s) >>> 14, and g1 is bit 0 of the second stream's Gold generator.
- R4: Each Gold bit is A[0] XOR B[0], taken before the step. A and B are 5-bit Fibonacci registers. On each step a register shifts toward bit 0 and loads bit 4 with the parity of (state AND taps). The taps are 0x05 for A and 0x1D for B. The seeds are A = 0x01, B = 0x01 for the first stream and B = 0x13 for the second.
- R5: A cycle with `step_en` low and `seed_load` low leaves both samples unchanged.
- R6: `out_valid_o` is high in exactly the cycle that follows a step. A step is a cycle with `step_en` high, `seed_load` low and `rst_n` high.
- R7: clamp() limits its argument to the range [−16384, 16384], so neither sample ever leaves [−1, +1].
- R8: `seed_load` acts like R1 and takes priority over `step_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance both maps by one iteration |
| seed_load | input | 1 | Restart maps and Gold generators from seeds |
| src0_o | output | 16 | Quadratic-map sample, signed Q1.14 |
| src1_o | output | 16 | Cubic-map sample, signed Q1.14 |
| out_valid_o | output | 1 | High the cycle after a step |

## Verification
The bench keeps the default word width, fraction width and 5-bit shift registers. With 5-bit registers each Gold sequence repeats every 31 steps, so one run covers many wraps of the injected bit pattern and both phase offsets. The bench overrides INIT1 to −16380. Starting this close to −1 pushes the cubic map against the edge of the unit interval straight away, where truncation and the injected bit can press a result toward the clamp. Step patterns that are continuous, random and idle are compared on every cycle against a model that is built from the arithmetic rules in the requirements.

// File: rtl/chaos_pkg.sv
// Package: shared defaults and the shift-register step used by the
// Gold generators. Assumes a register state never exceeds 32 bits.
package chaos_pkg;

    localparam int          DEF_WIDTH   = 16;
    localparam int          DEF_FRAC    = 14;
    localparam int          DEF_DEG     = 5;
    localparam logic [31:0] DEF_TAPS_A  = 32'h05;
    localparam logic [31:0] DEF_TAPS_B  = 32'h1D;
    localparam logic [31:0] DEF_SEED_A  = 32'h01;
    localparam logic [31:0] DEF_SEED_B0 = 32'h01;
    localparam logic [31:0] DEF_SEED_B1 = 32'h13;

    // One Fibonacci step: shift toward bit 0, parity of tapped bits enters at the top.
    function automatic logic [31:0] lfsr_advance(input logic [31:0] st,
                                                 input logic [31:0] taps,
                                                 input int          deg);
        logic fb;
        fb = ^(st & taps);
        lfsr_advance = (st >> 1) | ({31'd0, fb} << (deg - 1));
    endfunction

endpackage

// File: rtl/gold_gen.sv
// Gold sequence generator: XOR of bit 0 of two equal-degree shift registers.
// Assumes both seeds are nonzero and both tap sets are maximal-length.
module gold_gen
    import chaos_pkg::*;
#(
    parameter int          DEG    = DEF_DEG,
    parameter logic [31:0] TAPS_A = DEF_TAPS_A,
    parameter logic [31:0] TAPS_B = DEF_TAPS_B,
    parameter logic [31:0] SEED_A = DEF_SEED_A,
    parameter logic [31:0] SEED_B = DEF_SEED_B0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic advance,
    output logic bit_o
);

    logic [DEG-1:0] reg_a, reg_b;
    logic [31:0]    next_a, next_b;

    // Next register contents, computed at full package width.
    always_comb begin
        next_a = lfsr_advance(32'(reg_a), TAPS_A, DEG);
        next_b = lfsr_advance(32'(reg_b), TAPS_B, DEG);
    end

    // Load seeds on reset/reload, otherwise step both registers together.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            reg_a <= SEED_A[DEG-1:0];
            reg_b <= SEED_B[DEG-1:0];
        end else if (advance) begin
            reg_a <= next_a[DEG-1:0];
            reg_b <= next_b[DEG-1:0];
        end
    end

    // Output bit combines the low bits of both registers.
    assign bit_o = reg_a[0] ^ reg_b[0];

    initial begin
        p_seed_nonzero_r4: assert (SEED_A[DEG-1:0] != '0 && SEED_B[DEG-1:0] != '0)
            else $error("Gold seeds must be nonzero");
    end

    // A maximal-length register never reaches the all-zero lock-up state.
    p_lfsr_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a != '0) && (reg_b != '0));

endmodule

// File: rtl/cheb_map.sv
// Combinational Chebyshev map step in signed fixed point.
// ORDER selects T2 (2) or T3 (3). The result has its LSB XORed with inj_i
// and is then clamped to [-1, +1]. Assumes the input is already in range.
module cheb_map #(
    parameter int ORDER = 2,
    parameter int W     = 16,
    parameter int FRAC  = 14
) (
    input  logic [W-1:0] s_i,
    input  logic         inj_i,
    output logic [W-1:0] nxt_o
);

    localparam int                    PW    = 2 * W;
    localparam logic signed [PW-1:0]  ONE_Q = PW'(1) <<< FRAC;

    logic signed [PW-1:0] s_ext, sq, sq_q, poly, flipped;

    // Sign-extend the state and form its truncated square.
    always_comb begin
        s_ext = PW'($signed(s_i));
        sq    = s_ext * s_ext;
        sq_q  = sq >>> FRAC;
    end

    // Select the polynomial from the order parameter.
    generate
        if (ORDER == 2) begin : g_quad
            assign poly = (sq_q <<< 1) - ONE_Q;
        end else begin : g_cubic
            logic signed [PW-1:0] cube, cube_q;
            assign cube   = sq_q * s_ext;
            assign cube_q = cube >>> FRAC;
            assign poly   = (cube_q <<< 2) - (s_ext * PW'(3));
        end
    endgenerate

    // Inject the random bit into the LSB, then saturate to the unit interval.
    always_comb begin
        flipped = poly ^ {{(PW-1){1'b0}}, inj_i};
        if (flipped > ONE_Q)
            nxt_o = W'(ONE_Q);
        else if (flipped < -ONE_Q)
            nxt_o = W'(-ONE_Q);
        else
            nxt_o = W'(flipped);
    end

    initial begin
        p_order_legal_r2: assert (ORDER == 2 || ORDER == 3)
            else $error("cheb_map supports orders 2 and 3 only");
    end

endmodule

// File: rtl/chaos_pair_gen.sv
// Top: two chaotic sources (orders 2 and 3) with bit-harnessed LSBs.
// Each source owns a Gold generator and a state register. A step advances
// all of them; a reset or seed_load restarts them. Assumes the INIT values
// lie in [-1, +1] and are not fixed points of their maps.
module chaos_pair_gen
    import chaos_pkg::*;
#(
    parameter int          WIDTH    = DEF_WIDTH,
    parameter int          FRAC     = DEF_FRAC,
    parameter int          LFSR_DEG = DEF_DEG,
    parameter logic [31:0] TAPS_A   = DEF_TAPS_A,
    parameter logic [31:0] TAPS_B   = DEF_TAPS_B,
    parameter logic [31:0] GSEED_A  = DEF_SEED_A,
    parameter logic [31:0] GSEED_B0 = DEF_SEED_B0,
    parameter logic [31:0] GSEED_B1 = DEF_SEED_B1,
    parameter int          INIT0    = 4915,
    parameter int          INIT1    = -7373
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_load,
    output logic [WIDTH-1:0] src0_o,
    output logic [WIDTH-1:0] src1_o,
    output logic             out_valid_o
);

    localparam int NSRC = 2;
    localparam int ONE  = 1 << FRAC;

    logic [WIDTH-1:0] state_q [NSRC];
    logic             valid_q;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam int          ORD   = i + 2;
            localparam logic [31:0] BSEED = (i == 0) ? GSEED_B0 : GSEED_B1;
            localparam int          INITV = (i == 0) ? INIT0 : INIT1;

            logic             gbit;
            logic [WIDTH-1:0] nxt;

            gold_gen #(
                .DEG    (LFSR_DEG),
                .TAPS_A (TAPS_A),
                .TAPS_B (TAPS_B),
                .SEED_A (GSEED_A),
                .SEED_B (BSEED)
            ) u_gold (
                .clk     (clk),
                .rst_n   (rst_n),
                .reload  (seed_load),
                .advance (step_en),
                .bit_o   (gbit)
            );

            cheb_map #(
                .ORDER (ORD),
                .W     (WIDTH),
                .FRAC  (FRAC)
            ) u_map (
                .s_i   (state_q[i]),
                .inj_i (gbit),
                .nxt_o (nxt)
            );

            // State register: seed on reset/reload, new map value on a step.
            always_ff @(posedge clk) begin
                if (!rst_n || seed_load)
                    state_q[i] <= WIDTH'(INITV);
                else if (step_en)
                    state_q[i] <= nxt;
            end
        end
    endgenerate

    // Valid strobe marks the cycle after each accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load)
            valid_q <= 1'b0;
        else
            valid_q <= step_en;
    end

    assign src0_o      = state_q[0];
    assign src1_o      = state_q[1];
    assign out_valid_o = valid_q;

    initial begin
        p_init_ok_r1: assert (INIT0 >= -ONE && INIT0 <= ONE && INIT1 >= -ONE && INIT1 <= ONE
                              && INIT0 != ONE && INIT0 != -(ONE / 2)
                              && INIT1 != 0 && INIT1 != ONE && INIT1 != -ONE)
            else $error("INIT values out of range or at a map fixed point");
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_load) |=> ($stable(src0_o) && $stable(src1_o)));

    p_valid_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load) |=> out_valid_o);

    p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en) |=> !out_valid_o);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(src0_o) <= ONE) && ($signed(src0_o) >= -ONE) &&
        ($signed(src1_o) <= ONE) && ($signed(src1_o) >= -ONE));

    p_seed_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (src0_o == WIDTH'(INIT0)) && (src1_o == WIDTH'(INIT1)) && !out_valid_o);

endmodule

// File: tb/chaos_pair_gen_tb.sv
`timescale 1ns/1ps
module chaos_pair_gen_tb;

    localparam int INIT0 = 4915;
    localparam int INIT1 = -16380;

    logic        clk = 1'b0;
    logic        rst_n, step_en, seed_load;
    logic [15:0] src0_o, src1_o;
    logic        out_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit running  = 0;
    bit done     = 0;

    // Behavioural reference state.
    int m0, m1, ma0, mb0, ma1, mb1;
    bit mv;

    always #4 clk = ~clk;

    chaos_pair_gen #(.INIT0(INIT0), .INIT1(INIT1)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .seed_load   (seed_load),
        .src0_o      (src0_o),
        .src1_o      (src1_o),
        .out_valid_o (out_valid_o)
    );

    function automatic int lfsr5(int st, int taps);
        int fb;
        fb = $countones(st & taps) % 2;
        return (st >> 1) | (fb << 4);
    endfunction

    function automatic int clampu(int v);
        if (v > 16384) return 16384;
        if (v < -16384) return -16384;
        return v;
    endfunction

    function automatic int quad(int s, int g);
        int p;
        p = (s * s) >>> 14;
        return clampu((2 * p - 16384) ^ g);
    endfunction

    function automatic int cubic(int s, int g);
        int p, q;
        p = (s * s) >>> 14;
        q = (p * s) >>> 14;
        return clampu((4 * q - 3 * s) ^ g);
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n || seed_load) begin
            m0 = INIT0; m1 = INIT1;
            ma0 = 1; mb0 = 1; ma1 = 1; mb1 = 'h13;
            mv = 0;
        end else begin
            mv = step_en;
            if (step_en) begin
                m0  = quad(m0, (ma0 ^ mb0) & 1);
                m1  = cubic(m1, (ma1 ^ mb1) & 1);
                ma0 = lfsr5(ma0, 'h05); mb0 = lfsr5(mb0, 'h1D);
                ma1 = lfsr5(ma1, 'h05); mb1 = lfsr5(mb1, 'h1D);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2, R3 with R4 bits, R6, R7).
    always @(negedge clk) begin
        if (running) begin
            check($signed(src0_o) == m0, "R2 src0", $signed(src0_o), m0);
            check($signed(src1_o) == m1, "R3 src1", $signed(src1_o), m1);
            check(out_valid_o == mv, "R6 valid", out_valid_o, mv);
            check($signed(src0_o) >= -16384 && $signed(src0_o) <= 16384 &&
                  $signed(src1_o) >= -16384 && $signed(src1_o) <= 16384,
                  "R7 range", $signed(src1_o), 16384);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int h0, h1;
        rst_n = 0; step_en = 1; seed_load = 0;
        repeat (3) @(negedge clk);
        // R1: reset state despite step_en high.
        check($signed(src0_o) == INIT0, "R1 src0 reset", $signed(src0_o), INIT0);
        check($signed(src1_o) == INIT1, "R1 src1 reset", $signed(src1_o), INIT1);
        check(out_valid_o == 0, "R1 valid reset", out_valid_o, 0);
        running = 1;
        rst_n = 1;
        // Continuous stepping: Gold sequences (R4) wrap many times.
        repeat (300) @(negedge clk);
        // Random step pattern.
        for (int k = 0; k < 400; k++) begin
            step_en = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        // R5: idle holds the samples.
        step_en = 0;
        @(negedge clk);
        h0 = $signed(src0_o); h1 = $signed(src1_o);
        repeat (10) @(negedge clk);
        check($signed(src0_o) == h0, "R5 src0 hold", $signed(src0_o), h0);
        check($signed(src1_o) == h1, "R5 src1 hold", $signed(src1_o), h1);
        check(out_valid_o == 0, "R5 valid idle", out_valid_o, 0);
        // R8: seed_load wins over step_en.
        step_en = 1; seed_load = 1;
        @(negedge clk);
        check($signed(src0_o) == INIT0, "R8 src0 seed", $signed(src0_o), INIT0);
        check($signed(src1_o) == INIT1, "R8 src1 seed", $signed(src1_o), INIT1);
        check(out_valid_o == 0, "R8 valid seed", out_valid_o, 0);
        seed_load = 0;
        // Restarted run must replay from seeds.
        repeat (300) @(negedge clk);
        for (int k = 0; k < 100; k++) begin
            step_en = (k % 3) != 0;
            @(negedge clk);
        end
        running = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule